// File: doc/BRIEF.md
# Stack and Branch Sequencer

This block owns a program counter and a stack pointer and carries out the control-flow and stack steps of an 8-bit processor core. It supports six operations: relative jump, absolute jump, call, return, push of a 16-bit word and pop of a 16-bit word. It talks to memory over a byte-wide port with a 16-bit address. Each 16-bit quantity is moved as two single-byte accesses. The low byte sits at the lower address. Every access waits for a ready answer from memory.

A decoder outside the block raises `start` for one cycle with an operation code, and with the word to push when the operation is a push. The sequencer then runs its byte accesses without further help. It signals the end with a one-cycle `done` pulse, and at that point the new `pc`, `sp` and popped word are visible on its outputs. Instruction decode, arithmetic and interrupt handling belong to other blocks.

Top module: `stack_branch_seq`

## Requirements
- R1: While `rst` is high and after it falls, `pc` equals `PC_RESET` and `sp` equals `SP_RESET`, and `pop_data` is zero. `done`, `mem_req` and `mem_we` are low until a legal start arrives.
- R2: An access is presented with `mem_req` high. The address, the write enable and the write data stay unchanged until a clock edge at which `mem_ready` is high. Exactly one byte moves at each such edge.
- R3: `done` is high for exactly one cycle. That cycle is the one right after the edge that completes the operation's final byte transfer, and `mem_req` is low in it.
- R4: Operation codes are 0 relative jump, 1 absolute jump, 2 call, 3 return, 4 push and 5 pop. A start with code 6 or 7 is ignored, and so is a start raised while an operation is under way: neither causes any access nor changes `pc` or `sp`.
- R5: A relative jump reads one byte d at `pc`. It then sets `pc` to `pc` + sign-extended d + 1.
- R6: An absolute jump reads the low byte at `pc` and the high byte at `pc`+1, and loads the resulting word into `pc`.
- R7: A push lowers `sp` by 2 in the cycle after the start is accepted. It then writes the low byte of `push_data` at the new `sp` and the high byte at `sp`+1.
- R8: A pop reads the low byte at `sp` and the high byte at `sp`+1. It presents the word on `pop_data` and raises `sp` by 2 when it completes.
- R9: A call first pushes `pc`+2 as in R7, low byte first. It then runs an absolute jump from the unchanged `pc`, for four accesses in all.
- R10: A return pops a word as in R8 and loads it into `pc`.
- R11: All address and pointer arithmetic wraps modulo 65536.
- R12: Between operations, `pc` and `sp` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (one cycle) |
| op_code | input | 3 | Operation select, encoding in R4 |
| push_data | input | 16 | Word to push, sampled with the start |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| pop_data | output | 16 | Word taken by the last pop |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid when `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the access at this edge |

## Verification
The cycle-level contracts are checked on every cycle by properties. These are: a request held steady while memory stalls, a single-cycle `done` that follows a completed transfer, the early decrement of `sp` on a push, and `pc`/`sp` holding still while idle. The arithmetic content can only be shown by the bench scenarios, because it depends on what memory returned. That covers the jump targets for every displacement, the order of bytes and addresses in each operation, LIFO order over nested pushes and calls, wrap at the top of the address space, and the ignored starts.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OP_W   = 3;
    localparam int STEP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_JREL = 3'd0,
        OP_JABS = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_PUSH = 3'd4,
        OP_POP  = 3'd5
    } seq_op_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } mem_cmd_t;

    function automatic logic op_legal(input logic [OP_W-1:0] code);
        return code <= 3'd5;
    endfunction

    // index of the final byte access of each operation
    function automatic logic [STEP_W-1:0] op_last_step(input seq_op_e op);
        case (op)
            OP_JREL: return 2'd0;
            OP_CALL: return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    // the call writes its return word during its first two accesses
    function automatic logic step_is_write(input seq_op_e op, input logic [STEP_W-1:0] st);
        return (op == OP_PUSH) || (op == OP_CALL && !st[1]);
    endfunction

    function automatic logic step_uses_sp(input seq_op_e op, input logic [STEP_W-1:0] st);
        return (op == OP_PUSH) || (op == OP_POP) || (op == OP_RET) ||
               (op == OP_CALL && !st[1]);
    endfunction

    // the read that brings in the low byte of a two-byte word
    function automatic logic step_low_read(input seq_op_e op, input logic [STEP_W-1:0] st);
        return (op != OP_JREL) && !step_is_write(op, st) && !st[0];
    endfunction

    function automatic logic [ADDR_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
        return {{(ADDR_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op_code,
    input  logic              mem_ready,
    output logic              busy,
    output seq_op_e           op_q,
    output logic [STEP_W-1:0] step,
    output logic              accept,
    output logic              fire,
    output logic              last,
    output logic              done
);

    logic              busy_q;
    logic [STEP_W-1:0] step_q;
    logic              done_q;

    assign accept = start && !busy_q && op_legal(op_code);
    assign fire   = busy_q && mem_ready;
    assign last   = fire && (step_q == op_last_step(op_q));
    assign busy   = busy_q;
    assign step   = step_q;
    assign done   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            op_q   <= OP_JREL;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (accept) begin
                busy_q <= 1'b1;
                step_q <= '0;
                op_q   <= seq_op_e'(op_code);
            end else if (last) begin
                busy_q <= 1'b0;
            end else if (fire) begin
                step_q <= step_q + 2'd1;
            end
        end
    end

endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
    import sbs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_RESET = '0,
    parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [OP_W-1:0]   op_code,
    input  logic              busy,
    input  seq_op_e           op_q,
    input  logic [STEP_W-1:0] step,
    input  logic              fire,
    input  logic              last,
    input  logic [WORD_W-1:0] push_data,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic [WORD_W-1:0] pop_data,
    output mem_cmd_t          cmd
);

    logic [ADDR_W-1:0] pc_q, sp_q;
    logic [WORD_W-1:0] wval_q, pop_q;
    logic [BYTE_W-1:0] rlo_q;
    seq_op_e           op_new;
    logic [WORD_W-1:0] rword;

    assign op_new = seq_op_e'(op_code);
    assign rword  = {mem_rdata, rlo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= PC_RESET;
            sp_q   <= SP_RESET;
            wval_q <= '0;
            pop_q  <= '0;
            rlo_q  <= '0;
        end else begin
            if (accept) begin
                wval_q <= (op_new == OP_CALL) ? pc_q + 16'd2 : push_data;
                if (op_new == OP_PUSH || op_new == OP_CALL)
                    sp_q <= sp_q - 16'd2;
            end
            if (fire && step_low_read(op_q, step))
                rlo_q <= mem_rdata;
            if (last) begin
                case (op_q)
                    OP_JREL: pc_q <= pc_q + sext_byte(mem_rdata) + 16'd1;
                    OP_JABS,
                    OP_CALL: pc_q <= rword;
                    OP_RET: begin
                        pc_q <= rword;
                        sp_q <= sp_q + 16'd2;
                    end
                    OP_POP: begin
                        pop_q <= rword;
                        sp_q  <= sp_q + 16'd2;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        cmd.req   = busy;
        cmd.we    = busy && step_is_write(op_q, step);
        cmd.addr  = (step_uses_sp(op_q, step) ? sp_q : pc_q) + {{(ADDR_W-1){1'b0}}, step[0]};
        cmd.wdata = step[0] ? wval_q[WORD_W-1:BYTE_W] : wval_q[BYTE_W-1:0];
    end

    assign pc       = pc_q;
    assign sp       = sp_q;
    assign pop_data = pop_q;

endmodule

// File: rtl/stack_branch_seq.sv
module stack_branch_seq
    import sbs_pkg::*;
#(
    parameter logic [15:0] PC_RESET = 16'h0000,
    parameter logic [15:0] SP_RESET = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  op_code,
    input  logic [15:0] push_data,
    output logic [15:0] pc,
    output logic [15:0] sp,
    output logic [15:0] pop_data,
    output logic        done,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ready
);

    logic              busy, accept, fire, last;
    seq_op_e           op_q;
    logic [STEP_W-1:0] step;
    mem_cmd_t          cmd;

    sbs_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_code   (op_code),
        .mem_ready (mem_ready),
        .busy      (busy),
        .op_q      (op_q),
        .step      (step),
        .accept    (accept),
        .fire      (fire),
        .last      (last),
        .done      (done)
    );

    sbs_datapath #(
        .PC_RESET (PC_RESET),
        .SP_RESET (SP_RESET)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .op_code   (op_code),
        .busy      (busy),
        .op_q      (op_q),
        .step      (step),
        .fire      (fire),
        .last      (last),
        .push_data (push_data),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .sp        (sp),
        .pop_data  (pop_data),
        .cmd       (cmd)
    );

    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [2:0]  op_code,
    input logic [15:0] pc,
    input logic [15:0] sp,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_ready
);

    // R2: a stalled access is held unchanged
    a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    // R3: completion pulse lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: completion follows a finished transfer and ends the request
    a_r3_done_after_xfer: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_req && $past(mem_req && mem_ready)));

    // R7: push lowers the stack pointer right after acceptance
    a_r7_push_predec: assert property (@(posedge clk) disable iff (rst)
        (start && !mem_req && op_code == 3'd4) |=> (sp == $past(sp) - 16'd2));

    // R12: nothing moves while idle and not starting
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && !start) |=> ($stable(pc) && $stable(sp) && !mem_req));

    // R4: illegal codes never open a request
    a_r4_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && start && op_code > 3'd5) |=> !mem_req);

endmodule

bind stack_branch_seq sbs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_code   (op_code),
    .pc        (pc),
    .sp        (sp),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/stack_branch_seq_tb.sv
module stack_branch_seq_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] PC_RST     = 16'h0100;
    localparam logic [15:0] SP_RST     = 16'h0001;
    localparam int          WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [15:0] push_data = 16'h0;
    logic [15:0] pc, sp, pop_data, mem_addr;
    logic        done, mem_req, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;
    logic        mem_ready = 1'b1;

    stack_branch_seq #(.PC_RESET(PC_RST), .SP_RESET(SP_RST)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code),
        .push_data(push_data), .pc(pc), .sp(sp), .pop_data(pop_data),
        .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0]  wmem [logic [15:0]];
    logic [15:0] tr_addr [8];
    logic        tr_we [8];
    logic [7:0]  tr_dat [8];
    int          n_tr = 0;
    int          stalls = 0;
    int          done_cnt = 0;
    bit          rdy_mode = 1'b0;
    logic [7:0]  lfsr = 8'h5B;

    logic [15:0] pc_m, sp_m;

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [15:0] a);
        if (wmem.exists(a)) return wmem[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model and port monitor, acting just after each falling edge
    logic        p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0, p_done = 1'b0;
    logic [15:0] p_addr = 16'h0;
    logic [7:0]  p_wd = 8'h0;
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (p_req && !p_rdy) begin
                chk_eq("R2 req held", {31'd0, mem_req}, 32'd1);
                chk_eq("R2 addr held", {16'd0, mem_addr}, {16'd0, p_addr});
                chk_eq("R2 we held", {31'd0, mem_we}, {31'd0, p_we});
                if (p_we) chk_eq("R2 wdata held", {24'd0, mem_wdata}, {24'd0, p_wd});
            end
            if (done && p_done) chk_eq("R3 done width", 32'd2, 32'd1);
            if (done) done_cnt++;
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = rdy_mode ? lfsr[0] : 1'b1;
        mem_rdata = rd(mem_addr);
        if (mem_req && !mem_ready) stalls++;
        if (mem_req && mem_ready) begin
            if (n_tr < 8) begin
                tr_addr[n_tr] = mem_addr;
                tr_we[n_tr]   = mem_we;
                tr_dat[n_tr]  = mem_we ? mem_wdata : mem_rdata;
            end
            n_tr++;
            if (mem_we) wmem[mem_addr] = mem_wdata;
        end
        p_req = mem_req; p_rdy = mem_ready; p_we = mem_we;
        p_addr = mem_addr; p_wd = mem_wdata; p_done = done;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic run_op(input logic [2:0] op, input logic [15:0] pd);
        int cnt;
        n_tr = 0;
        start = 1'b1; op_code = op; push_data = pd;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        if (!done) chk_eq("R3 done never seen", 32'd0, 32'd1);
    endtask

    task automatic chk_acc(input string tag, input int i, input logic we,
                           input logic [15:0] a, input logic [7:0] d);
        chk_eq({tag, " addr"}, {16'd0, tr_addr[i]}, {16'd0, a});
        chk_eq({tag, " we"}, {31'd0, tr_we[i]}, {31'd0, we});
        chk_eq({tag, " data"}, {24'd0, tr_dat[i]}, {24'd0, d});
    endtask

    task automatic do_jr(input logic [7:0] d);
        logic [15:0] exp;
        wmem[pc_m] = d;
        exp = pc_m + {{8{d[7]}}, d} + 16'd1;
        run_op(3'd0, 16'h0);
        chk_eq("R5 jr access count", n_tr, 1);
        chk_acc("R5 jr read", 0, 1'b0, pc_m, d);
        chk_eq("R5 jr pc", {16'd0, pc}, {16'd0, exp});
        pc_m = exp;
    endtask

    task automatic do_jp(input logic [15:0] t);
        wmem[pc_m] = t[7:0];
        wmem[pc_m + 16'd1] = t[15:8];
        run_op(3'd1, 16'h0);
        chk_eq("R6 jp access count", n_tr, 2);
        chk_acc("R6 jp low", 0, 1'b0, pc_m, t[7:0]);
        chk_acc("R6 jp high", 1, 1'b0, pc_m + 16'd1, t[15:8]);
        chk_eq("R6 jp pc", {16'd0, pc}, {16'd0, t});
        pc_m = t;
    endtask

    task automatic do_push(input logic [15:0] v);
        logic [15:0] se;
        se = sp_m - 16'd2;
        run_op(3'd4, v);
        chk_eq("R7 push access count", n_tr, 2);
        chk_acc("R7 push low", 0, 1'b1, se, v[7:0]);
        chk_acc("R7 push high", 1, 1'b1, se + 16'd1, v[15:8]);
        chk_eq("R7 push sp", {16'd0, sp}, {16'd0, se});
        sp_m = se;
    endtask

    task automatic do_pop(input logic [15:0] v);
        run_op(3'd5, 16'h0);
        chk_eq("R8 pop access count", n_tr, 2);
        chk_acc("R8 pop low", 0, 1'b0, sp_m, v[7:0]);
        chk_acc("R8 pop high", 1, 1'b0, sp_m + 16'd1, v[15:8]);
        chk_eq("R8 pop data", {16'd0, pop_data}, {16'd0, v});
        sp_m = sp_m + 16'd2;
        chk_eq("R8 pop sp", {16'd0, sp}, {16'd0, sp_m});
    endtask

    task automatic do_call(input logic [15:0] t);
        logic [15:0] rv, se;
        rv = pc_m + 16'd2;
        se = sp_m - 16'd2;
        wmem[pc_m] = t[7:0];
        wmem[pc_m + 16'd1] = t[15:8];
        run_op(3'd2, 16'h0);
        chk_eq("R9 call access count", n_tr, 4);
        chk_acc("R9 call ret low", 0, 1'b1, se, rv[7:0]);
        chk_acc("R9 call ret high", 1, 1'b1, se + 16'd1, rv[15:8]);
        chk_acc("R9 call tgt low", 2, 1'b0, pc_m, t[7:0]);
        chk_acc("R9 call tgt high", 3, 1'b0, pc_m + 16'd1, t[15:8]);
        chk_eq("R9 call pc", {16'd0, pc}, {16'd0, t});
        chk_eq("R9 call sp", {16'd0, sp}, {16'd0, se});
        pc_m = t; sp_m = se;
    endtask

    task automatic do_ret(input logic [15:0] v);
        run_op(3'd3, 16'h0);
        chk_eq("R10 ret access count", n_tr, 2);
        chk_acc("R10 ret low", 0, 1'b0, sp_m, v[7:0]);
        chk_acc("R10 ret high", 1, 1'b0, sp_m + 16'd1, v[15:8]);
        chk_eq("R10 ret pc", {16'd0, pc}, {16'd0, v});
        sp_m = sp_m + 16'd2;
        chk_eq("R10 ret sp", {16'd0, sp}, {16'd0, sp_m});
        pc_m = v;
    endtask

    initial begin
        logic [15:0] rets [4];
        logic [15:0] vals [8];
        int dc;

        repeat (3) @(negedge clk);
        chk_eq("R1 pc in reset", {16'd0, pc}, {16'd0, PC_RST});
        chk_eq("R1 sp in reset", {16'd0, sp}, {16'd0, SP_RST});
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 pc after reset", {16'd0, pc}, {16'd0, PC_RST});
        chk_eq("R1 sp after reset", {16'd0, sp}, {16'd0, SP_RST});
        chk_eq("R1 pop_data", {16'd0, pop_data}, 32'd0);
        chk_eq("R1 done low", {31'd0, done}, 32'd0);
        chk_eq("R1 req low", {31'd0, mem_req}, 32'd0);
        chk_eq("R1 we low", {31'd0, mem_we}, 32'd0);
        pc_m = PC_RST; sp_m = SP_RST;

        // R11: push across the top of memory from sp=0001, then pop it back
        do_jp(16'h2000);
        do_push(16'hBEEF);
        chk_eq("R11 sp wrapped", {16'd0, sp}, 32'h0000FFFF);
        do_pop(16'hBEEF);

        rdy_mode = 1'b1;

        // R5: every displacement
        for (int d = 0; d < 256; d++) do_jr(d[7:0]);

        // R6 sweep and R11 wrap of operand address and of jump target
        for (int k = 0; k < 32; k++) do_jp(16'h0300 + k[15:0] * 16'h0101);
        do_jp(16'hFFFF);
        do_jp(16'h4000);
        do_jp(16'hFFFF);
        do_jr(8'h05);
        chk_eq("R11 jr wrap pc", {16'd0, pc}, 32'h00000005);
        do_jp(16'h3000);

        // R7/R8: LIFO order
        for (int i = 0; i < 8; i++) begin
            vals[i] = 16'h0A0B + i[15:0] * 16'h1357;
            do_push(vals[i]);
        end
        for (int i = 7; i >= 0; i--) do_pop(vals[i]);

        // R9/R10: nested calls unwound by returns
        for (int i = 0; i < 4; i++) begin
            rets[i] = pc_m + 16'd2;
            do_call(16'h5000 + i[15:0] * 16'h0400);
        end
        for (int i = 3; i >= 0; i--) do_ret(rets[i]);

        // R4: start during a call is dropped
        wmem[pc_m] = 8'h00;
        wmem[pc_m + 16'd1] = 8'h70;
        n_tr = 0;
        start = 1'b1; op_code = 3'd2;
        @(negedge clk);
        start = 1'b1; op_code = 3'd4; push_data = 16'h1234;
        @(negedge clk);
        start = 1'b0;
        dc = 0;
        while (!done && dc < 200) begin @(negedge clk); dc++; end
        repeat (4) @(negedge clk);
        chk_eq("R4 busy start accesses", n_tr, 4);
        chk_eq("R4 busy start sp", {16'd0, sp}, {16'd0, sp_m - 16'd2});
        chk_eq("R4 busy start pc", {16'd0, pc}, 32'h00007000);
        pc_m = 16'h7000; sp_m = sp_m - 16'd2;

        // R4/R12: illegal codes do nothing
        n_tr = 0;
        dc = done_cnt;
        start = 1'b1; op_code = 3'd6;
        @(negedge clk);
        op_code = 3'd7;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk_eq("R4 illegal accesses", n_tr, 0);
        chk_eq("R4 illegal done", done_cnt, dc);
        chk_eq("R12 idle pc", {16'd0, pc}, {16'd0, pc_m});
        chk_eq("R12 idle sp", {16'd0, sp}, {16'd0, sp_m});

        checks++;
        if (stalls == 0) begin
            failures++;
            $display("FAIL R2 stall coverage actual=%0d expected>0", stalls);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule